// File: doc/BRIEF.md
# Pixel-Valid Strobe with Set/Clear Decode

The block turns a three-bit condition code into a registered valid strobe for a pixel pipeline. Two combinational decoders look at the code. One recognises the pattern that starts a valid window, and the other recognises the pattern that ends it. A state bit is clocked on the rising edge. A start match sets it, an end match clears it, and it keeps its value at any other time.

A second register copies the state bit one clock later and drives the valid output. The strobe therefore lines up with pixel data that leaves its own pipeline stage one cycle after the decision is made. A hold input freezes both registers. An active-low reset clears both registers asynchronously.

The condition code is formed from three pins: `cond_a` is the most significant bit and `cond_c` the least. The decodes and the state bit are brought out as outputs, so that a system can observe the window before it is delayed.

Top module: `pv_valid_strobe`

## Requirements
- R1: `set_req` is 1 exactly when {cond_a,cond_b,cond_c} equals 3'b010. It is 0 for the other seven codes.
- R2: `clr_req` is 1 exactly when {cond_a,cond_b,cond_c} equals 3'b111. It is 0 for the other seven codes.
- R3: `set_req` and `clr_req` are purely combinational functions of the condition pins. Their values do not depend on `rst_n`, `hold` or the register state.
- R4: On a rising clock edge with reset high, hold low and `set_req` high, `flag` becomes 1.
- R5: On a rising clock edge with reset high, hold low and `clr_req` high, `flag` becomes 0. The two decodes are never 1 together, and the clear request has priority over the set request.
- R6: On a rising clock edge with reset high, hold low and neither request active, `flag` keeps its value.
- R7: On a rising clock edge with reset high and hold high, `flag` and `valid` both keep their values, whatever requests are present.
- R8: On a rising clock edge with reset high and hold low, `valid` takes the value that `flag` had just before that edge. This applies when `flag` rises and when it falls.
- R9: While `rst_n` is 0, `flag` and `valid` are 0, whether or not `hold` is asserted. Reset has priority over hold.
- R10: A change on the condition pins between clock edges leaves `flag` and `valid` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| hold | input | 1 | Freezes both registers while high |
| cond_a | input | 1 | Condition code bit 2 (MSB) |
| cond_b | input | 1 | Condition code bit 1 |
| cond_c | input | 1 | Condition code bit 0 (LSB) |
| set_req | output | 1 | Combinational start-window decode |
| clr_req | output | 1 | Combinational end-window decode |
| flag | output | 1 | Undelayed window state |
| valid | output | 1 | Window state delayed by one clock |

## Verification
Two updates can fall on the same edge: a request can arrive while hold is high, and a flag transition can happen on the same edge where valid copies the previous flag. The bench provokes the first case by raising hold with the set or clear code present. It then confirms that neither register moves. It provokes the second case with back-to-back set and clear codes, so that flag and valid toggle in opposite directions on one edge. A reference model updates both values from the state before the edge, and each result is judged against that model.

// File: rtl/pv_pkg.sv
package pv_pkg;

  localparam int unsigned PV_COND_W = 3;

  typedef logic [PV_COND_W-1:0] pv_cond_t;

  typedef struct packed {
    logic clr;
    logic set;
  } pv_req_t;

  // Match the condition code against the two window codes.
  function automatic pv_req_t pv_decode(input pv_cond_t cond,
                                        input pv_cond_t set_code,
                                        input pv_cond_t clr_code);
    pv_req_t r;
    r.set = (cond == set_code);
    r.clr = (cond == clr_code);
    return r;
  endfunction

  // Clear request wins over set request; no request keeps the value.
  function automatic logic pv_next_flag(input logic cur, input pv_req_t r);
    if (r.clr)      return 1'b0;
    else if (r.set) return 1'b1;
    else            return cur;
  endfunction

endpackage

// File: rtl/pv_decode.sv
module pv_decode
  import pv_pkg::*;
#(
  parameter pv_cond_t SET_CODE = 3'b010,
  parameter pv_cond_t CLR_CODE = 3'b111
) (
  input  pv_cond_t cond,
  output pv_req_t  req
);

  always_comb req = pv_decode(cond, SET_CODE, CLR_CODE);

endmodule

// File: rtl/pv_flag_reg.sv
module pv_flag_reg
  import pv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold,
  input  pv_req_t req,
  output logic    flag_q
);

  logic flag_d;

  always_comb begin
    if (hold) flag_d = flag_q;
    else      flag_d = pv_next_flag(flag_q, req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/pv_delay_reg.sv
module pv_delay_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (!hold) q <= d;
  end

endmodule

// File: rtl/pv_valid_strobe.sv
module pv_valid_strobe
  import pv_pkg::*;
#(
  parameter logic [2:0] SET_CODE = 3'b010,
  parameter logic [2:0] CLR_CODE = 3'b111
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic cond_a,
  input  logic cond_b,
  input  logic cond_c,
  output logic set_req,
  output logic clr_req,
  output logic flag,
  output logic valid
);

  pv_cond_t cond;
  pv_req_t  req;
  logic     flag_q;
  logic     valid_q;

  assign cond = {cond_a, cond_b, cond_c};

  pv_decode #(
    .SET_CODE (SET_CODE),
    .CLR_CODE (CLR_CODE)
  ) u_decode (
    .cond (cond),
    .req  (req)
  );

  pv_flag_reg u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .req    (req),
    .flag_q (flag_q)
  );

  pv_delay_reg u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .d     (flag_q),
    .q     (valid_q)
  );

  assign set_req = req.set;
  assign clr_req = req.clr;
  assign flag    = flag_q;
  assign valid   = valid_q;

endmodule

// File: rtl/pv_valid_strobe_chk.sv
module pv_valid_strobe_chk (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic set_req,
  input logic clr_req,
  input logic flag,
  input logic valid
);

  // Named events used by the properties below.
  wire upd   = !hold;
  wire idle  = upd && !set_req && !clr_req;

  assert_req_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_req, clr_req}));

  assert_set_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && set_req) |=> flag);

  assert_clr_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && clr_req) |=> !flag);

  assert_idle_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(flag));

  assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(flag) && $stable(valid)));

  assert_valid_lags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (valid == $past(flag)));

endmodule

bind pv_valid_strobe pv_valid_strobe_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .hold    (hold),
  .set_req (set_req),
  .clr_req (clr_req),
  .flag    (flag),
  .valid   (valid)
);

// File: tb/test_pv_valid_strobe.sv
`timescale 1ns/1ps
module test_pv_valid_strobe;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0;
  logic cond_a = 1'b0, cond_b = 1'b0, cond_c = 1'b0;
  logic set_req, clr_req, flag, valid;

  int compared = 0;
  int mismatched = 0;
  logic m_flag = 1'b0;
  logic m_valid = 1'b0;

  always #2 clk = ~clk;

  pv_valid_strobe i_pv_valid_strobe (
    .clk (clk), .rst_n (rst_n), .hold (hold),
    .cond_a (cond_a), .cond_b (cond_b), .cond_c (cond_c),
    .set_req (set_req), .clr_req (clr_req), .flag (flag), .valid (valid)
  );

  function automatic logic want_set(input logic [2:0] c);
    return (c[2] == 1'b0) && (c[1] == 1'b1) && (c[0] == 1'b0);
  endfunction

  function automatic logic want_clr(input logic [2:0] c);
    return c[2] & c[1] & c[0];
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, check before and after the rising edge.
  task automatic step(input logic r, input logic h, input logic [2:0] c);
    string tag;
    logic s, k;
    @(negedge clk);
    rst_n = r; hold = h; {cond_a, cond_b, cond_c} = c;
    if (!r) begin m_flag = 1'b0; m_valid = 1'b0; end
    #1;
    s = want_set(c); k = want_clr(c);
    check("R1", "set_req", set_req, s);
    check("R2", "clr_req", clr_req, k);
    if (!r || h) check("R3", "decode independent of rst/hold", set_req | clr_req, s | k);
    check(r ? "R10" : "R9", "flag before edge", flag, m_flag);
    check(r ? "R10" : "R9", "valid before edge", valid, m_valid);
    @(posedge clk);
    if (!r) begin
      m_flag = 1'b0; m_valid = 1'b0; tag = "R9";
    end else if (h) begin
      tag = "R7";
    end else begin
      m_valid = m_flag;
      if (k)      begin m_flag = 1'b0; tag = "R5"; end
      else if (s) begin m_flag = 1'b1; tag = "R4"; end
      else        tag = "R6";
    end
    #1;
    check(tag, "flag after edge", flag, m_flag);
    check((!r) ? "R9" : (h ? "R7" : "R8"), "valid after edge", valid, m_valid);
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // Reset state, including reset with hold high (R9).
    step(1'b0, 1'b0, 3'd0);
    step(1'b0, 1'b1, 3'd2);
    step(1'b0, 1'b0, 3'd7);
    // Binary walk of the condition code, twice (R1, R2, R4, R5, R6, R8).
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 8; c++) step(1'b1, 1'b0, 3'(c));
    // Back-to-back set and clear: flag and valid move opposite ways on one edge.
    step(1'b1, 1'b0, 3'b010);
    step(1'b1, 1'b0, 3'b111);
    step(1'b1, 1'b0, 3'b010);
    step(1'b1, 1'b0, 3'b000);
    // Hold against a pending clear and a pending set (R7).
    step(1'b1, 1'b1, 3'b111);
    step(1'b1, 1'b1, 3'b111);
    step(1'b1, 1'b0, 3'b111);
    step(1'b1, 1'b1, 3'b010);
    step(1'b1, 1'b0, 3'b001);
    // Reset while set, then with hold (R9 over R7).
    step(1'b1, 1'b0, 3'b010);
    step(1'b0, 1'b1, 3'b010);
    step(1'b1, 1'b0, 3'b000);
    // Random traffic.
    for (int i = 0; i < 3000; i++) begin
      logic r, h;
      logic [2:0] c;
      r = ($urandom % 40) != 0;
      h = ($urandom % 5) == 0;
      case ($urandom % 4)
        0: c = 3'b010;
        1: c = 3'b111;
        default: c = 3'($urandom);
      endcase
      step(r, h, c);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule